// File: doc/BRIEF.md
# Leaf Access Permission Checker

This block judges one memory access against the final (leaf) descriptor that a page-table walk has reached. It takes the leaf's attribute bits, the restrictions gathered from the table descriptors passed on the way down, the current privilege mode and the access kind. From these it decides, in the same cycle, whether the access is a protection violation and which of read, write and execute the translation may grant once it is cached in a TLB entry.

When the access is refused, the block also gives the exception parameter and a cause code that tells the exception logic which kind of access failed. It is purely combinational: the walker presents the inputs, and the fault path and the TLB fill path use the outputs in that same cycle. It does not walk tables and it stores nothing.

Kernel mode and user mode read the table restrictions differently. Restrictions that deny user access leave kernel accesses untouched. Execute-never applies only to the mode that is running. The read-only bit and the no-write restriction bind both modes.

Top module: `leaf_perm_check`

## Requirements
- R1: A write (`acc_kind` = 1) to a leaf whose read-only bit (descriptor bit 7) is set is a violation, whether `user_mode` is 0 (kernel) or 1 (user).
- R2: In kernel mode a fetch (`acc_kind` = 2) is a violation when leaf bit 53 (kernel execute-never) or restriction bit 0 (inherited kernel execute-never) is set. Kernel reads, and kernel writes to a leaf that is not read-only, are never violations.
- R3: In user mode a read (`acc_kind` = 0) or a write is a violation when restriction bit 2 (no user read/write) is set. A fetch is not refused by that bit.
- R4: In user mode a fetch is a violation when leaf bit 54 (user execute-never) or restriction bit 1 (inherited user execute-never) is set. The kernel execute-never sources do not refuse a user fetch.
- R5: In user mode a read, write or fetch is a violation when restriction bit 4 (no user mode) is set or leaf bit 6 (user-accessible) is clear.
- R6: A debug access (`acc_kind` = 3) never signals a violation, and in that case `exc_param` and `exc_cause` are zero.
- R7: `perm_rwx` bit 0 is read, bit 1 is write and bit 2 is execute. All three start set. Execute is cleared only by the execute-never sources of the current mode (leaf bit 53 or restriction bit 0 in kernel mode; leaf bit 54 or restriction bit 1 in user mode).
- R8: In user mode all three permission bits are cleared when restriction bit 4 is set or leaf bit 6 is clear. In kernel mode these conditions leave the mask unchanged.
- R9: Write permission is cleared in both modes by restriction bit 3 (no write) or by leaf bit 7. Restriction bit 3 on its own is never a violation.
- R10: In user mode read and write permission are cleared when restriction bit 2 is set. In kernel mode that bit leaves the mask unchanged.
- R11: On a violation `exc_param` is 0x08, and `exc_cause` is 0x01 for a read, 0x02 for a write and 0x04 for a fetch. Without a violation both are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| leaf_desc | input | 64 | Leaf descriptor word: bit 6 user-accessible, bit 7 read-only, bit 53 kernel execute-never, bit 54 user execute-never |
| tbl_restrict | input | 5 | Inherited restrictions: bit 0 kernel XN, bit 1 user XN, bit 2 no user read/write, bit 3 no write, bit 4 no user mode |
| user_mode | input | 1 | Status user-mode flag; 0 means kernel mode |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 debug |
| viol | output | 1 | Protection violation for this access |
| perm_rwx | output | 3 | Permissions to grant in the TLB entry: bit 0 R, bit 1 W, bit 2 X |
| exc_param | output | 8 | Exception parameter, 0x08 on a violation |
| exc_cause | output | 8 | Cause code: one-hot access kind on a violation |

## Verification
The verdict and the permission mask are computed side by side from the same inputs, so a single access both refuses and shapes the mask. The bench applies input mixes where one source trips a violation while others remove mask bits. Examples are a user write to a read-only leaf under the no-user read/write restriction, and a kernel fetch refused by execute-never where the mask still grants read and write. Each such case is judged on the verdict, the mask and the exception fields together. Debug accesses with every refusing source set confirm that the mask is still reduced while the verdict stays clear.

// File: rtl/leaf_perm_pkg.sv
// Package: shared types for the leaf permission checker.
// Assumes one 64-bit descriptor word and five inherited restriction bits.
package leaf_perm_pkg;

    localparam int DESC_W      = 64;
    localparam int RSTR_W      = 5;
    localparam int EXC_W       = 8;
    localparam int PERM_W      = 3;

    // Bit positions inside the descriptor that the checker reads.
    localparam int BIT_USER_OK = 6;
    localparam int BIT_RDONLY  = 7;
    localparam int BIT_KXN     = 53;
    localparam int BIT_UXN     = 54;

    // Mask bit positions.
    localparam int PRM_R = 0;
    localparam int PRM_W = 1;
    localparam int PRM_X = 2;

    localparam logic [EXC_W-1:0] PROT_PARAM = 8'h08;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_FE  = 2'd2,
        ACC_DBG = 2'd3
    } acc_kind_e;

    // Inherited restrictions; bit 0 is kxn, bit 4 is no_user.
    typedef struct packed {
        logic no_user;
        logic no_write;
        logic no_user_rw;
        logic uxn;
        logic kxn;
    } restrict_t;

    typedef struct packed {
        logic user_ok;
        logic rdonly;
        logic kxn;
        logic uxn;
    } leaf_attr_t;

endpackage

// File: rtl/leaf_attr_decode.sv
// Module: leaf_attr_decode
// Pulls the permission-relevant attribute bits out of a leaf descriptor.
// Assumes the descriptor is a leaf; the descriptor type is not checked here.
module leaf_attr_decode
    import leaf_perm_pkg::*;
#(
    parameter int W        = DESC_W,
    parameter int P_USEROK = BIT_USER_OK,
    parameter int P_RDONLY = BIT_RDONLY,
    parameter int P_KXN    = BIT_KXN,
    parameter int P_UXN    = BIT_UXN
) (
    input  logic [W-1:0] desc,
    output leaf_attr_t   attr
);

    // Select the four attribute bits from the descriptor.
    always_comb begin
        attr.user_ok = desc[P_USEROK];
        attr.rdonly  = desc[P_RDONLY];
        attr.kxn     = desc[P_KXN];
        attr.uxn     = desc[P_UXN];
    end

endmodule

// File: rtl/leaf_viol_judge.sv
// Module: leaf_viol_judge
// Decides whether an access to a leaf is a protection violation.
// Assumes a debug access is never refused.
module leaf_viol_judge
    import leaf_perm_pkg::*;
(
    input  leaf_attr_t attr,
    input  restrict_t  rstr,
    input  logic       user,
    input  acc_kind_e  kind,
    output logic       bad
);

    logic is_rd, is_wr, is_fe, kern_bad, usr_bad;

    // Classify the access kind.
    always_comb begin
        is_rd = (kind == ACC_RD);
        is_wr = (kind == ACC_WR);
        is_fe = (kind == ACC_FE);
    end

    // Kernel-side refusals: execute-never on fetch.
    always_comb begin
        kern_bad = is_fe && (attr.kxn || rstr.kxn);
    end

    // User-side refusals: data lockout, execute-never, whole-region lockout.
    always_comb begin
        usr_bad = ((is_rd || is_wr) && rstr.no_user_rw)
               || (is_fe && (attr.uxn || rstr.uxn))
               || ((is_rd || is_wr || is_fe) && (rstr.no_user || !attr.user_ok));
    end

    // Combine the mode-specific verdict with the read-only write check.
    always_comb begin
        bad = (is_wr && attr.rdonly) || (user ? usr_bad : kern_bad);
    end

endmodule

// File: rtl/leaf_mask_build.sv
// Module: leaf_mask_build
// Builds the read/write/execute mask to install in a TLB entry.
// Assumes the mask starts fully open and is only ever reduced.
module leaf_mask_build
    import leaf_perm_pkg::*;
#(
    parameter int N = PERM_W
) (
    input  leaf_attr_t   attr,
    input  restrict_t    rstr,
    input  logic         user,
    output logic [N-1:0] mask
);

    logic xn_now, usr_lock, usr_data_lock, wr_lock;

    // Gather the conditions that remove permission bits.
    always_comb begin
        xn_now        = user ? (attr.uxn || rstr.uxn) : (attr.kxn || rstr.kxn);
        usr_lock      = user && (rstr.no_user || !attr.user_ok);
        usr_data_lock = user && rstr.no_user_rw;
        wr_lock       = rstr.no_write || attr.rdonly;
    end

    // Apply each removal to the fully open mask.
    always_comb begin
        mask = '1;
        if (xn_now)        mask[PRM_X] = 1'b0;
        if (wr_lock)       mask[PRM_W] = 1'b0;
        if (usr_data_lock) begin
            mask[PRM_R] = 1'b0;
            mask[PRM_W] = 1'b0;
        end
        if (usr_lock)      mask = '0;
    end

endmodule

// File: rtl/leaf_perm_check.sv
// Module: leaf_perm_check (top)
// Judges one access against a leaf descriptor and the inherited table
// restrictions, giving a violation flag, a TLB permission mask and the
// exception parameter and cause. Purely combinational, no state.
module leaf_perm_check
    import leaf_perm_pkg::*;
#(
    parameter int DW = DESC_W,
    parameter int RW = RSTR_W,
    parameter int EW = EXC_W
) (
    input  logic [DW-1:0]     leaf_desc,
    input  logic [RW-1:0]     tbl_restrict,
    input  logic              user_mode,
    input  logic [1:0]        acc_kind,
    output logic              viol,
    output logic [PERM_W-1:0] perm_rwx,
    output logic [EW-1:0]     exc_param,
    output logic [EW-1:0]     exc_cause
);

    localparam int CAUSE_BITS = 3;

    leaf_attr_t attr;
    restrict_t  rstr;
    acc_kind_e  kind;
    logic       bad;

    // Map raw inputs onto the package types.
    always_comb begin
        rstr = restrict_t'(tbl_restrict);
        kind = acc_kind_e'(acc_kind);
    end

    leaf_attr_decode #(.W(DW)) u_dec (
        .desc (leaf_desc),
        .attr (attr)
    );

    leaf_viol_judge u_judge (
        .attr (attr),
        .rstr (rstr),
        .user (user_mode),
        .kind (kind),
        .bad  (bad)
    );

    leaf_mask_build #(.N(PERM_W)) u_mask (
        .attr (attr),
        .rstr (rstr),
        .user (user_mode),
        .mask (perm_rwx)
    );

    // Encode the exception fields for a refused access.
    always_comb begin
        viol      = bad;
        exc_param = bad ? PROT_PARAM : '0;
        exc_cause = '0;
        if (bad) begin
            for (int i = 0; i < CAUSE_BITS; i++) begin
                if (acc_kind == 2'(i)) exc_cause[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/leaf_perm_check_sva.sv
// Module: leaf_perm_check_sva
// Checker bound to leaf_perm_check; relates its ports with immediate
// assertions because the block has no clock.
module leaf_perm_check_sva (
    input logic [63:0] leaf_desc,
    input logic [4:0]  tbl_restrict,
    input logic        user_mode,
    input logic [1:0]  acc_kind,
    input logic        viol,
    input logic [2:0]  perm_rwx,
    input logic [7:0]  exc_param,
    input logic [7:0]  exc_cause
);

    // Port-level consistency checks.
    always_comb begin
        a_r1_ro_write: assert (!(acc_kind == 2'd1 && leaf_desc[7]) || viol);
        a_r2_kernel_fetch: assert (!(!user_mode && acc_kind == 2'd2
                                     && (leaf_desc[53] || tbl_restrict[0])) || viol);
        a_r5_user_lock: assert (!(user_mode && acc_kind != 2'd3
                                  && (tbl_restrict[4] || !leaf_desc[6])) || viol);
        a_r6_debug_quiet: assert (acc_kind != 2'd3 || (!viol && exc_cause == 8'h00));
        a_r8_mask_closed: assert (!(user_mode && (tbl_restrict[4] || !leaf_desc[6]))
                                  || perm_rwx == 3'b000);
        a_r9_no_write: assert (!(tbl_restrict[3] || leaf_desc[7]) || !perm_rwx[1]);
        a_r11_param: assert (viol ? (exc_param == 8'h08 && $onehot(exc_cause))
                                  : (exc_param == 8'h00 && exc_cause == 8'h00));
    end

endmodule

bind leaf_perm_check leaf_perm_check_sva u_sva (
    .leaf_desc    (leaf_desc),
    .tbl_restrict (tbl_restrict),
    .user_mode    (user_mode),
    .acc_kind     (acc_kind),
    .viol         (viol),
    .perm_rwx     (perm_rwx),
    .exc_param    (exc_param),
    .exc_cause    (exc_cause)
);

// File: tb/sim_leaf_perm_check.sv
// Directed bench for leaf_perm_check: one task per scenario.
module sim_leaf_perm_check;

    logic        clk = 1'b0;
    logic [63:0] leaf_desc = '0;
    logic [4:0]  tbl_restrict = '0;
    logic        user_mode = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic        viol;
    logic [2:0]  perm_rwx;
    logic [7:0]  exc_param;
    logic [7:0]  exc_cause;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    leaf_perm_check u0 (
        .leaf_desc    (leaf_desc),
        .tbl_restrict (tbl_restrict),
        .user_mode    (user_mode),
        .acc_kind     (acc_kind),
        .viol         (viol),
        .perm_rwx     (perm_rwx),
        .exc_param    (exc_param),
        .exc_cause    (exc_cause)
    );

    // Descriptor with chosen attribute bits; low bits mark a valid leaf.
    function automatic logic [63:0] mk(input logic ro, input logic uok,
                                       input logic kxn, input logic uxn);
        logic [63:0] d;
        d = 64'h0000_1234_5000_0003;
        d[7] = ro; d[6] = uok; d[53] = kxn; d[54] = uxn;
        return d;
    endfunction

    task automatic apply(input logic [63:0] d, input logic [4:0] r,
                         input logic u, input logic [1:0] k);
        @(negedge clk);
        leaf_desc = d; tbl_restrict = r; user_mode = u; acc_kind = k;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic v, input logic [2:0] m,
                           input logic [7:0] c);
        chk({tag, " viol"}, {7'd0, viol}, {7'd0, v});
        chk({tag, " mask"}, {5'd0, perm_rwx}, {5'd0, m});
        chk({tag, " param"}, exc_param, v ? 8'h08 : 8'h00);
        chk({tag, " cause"}, exc_cause, c);
    endtask

    task automatic t_open();
        apply(mk(0,1,0,0), 5'b00000, 1'b0, 2'd0);
        chk_all("R7 open kernel read", 0, 3'b111, 8'h00);
        apply(mk(0,1,0,0), 5'b00000, 1'b1, 2'd1);
        chk_all("R7 open user write", 0, 3'b111, 8'h00);
    endtask

    task automatic t_rdonly();
        apply(mk(1,1,0,0), 5'b00000, 1'b0, 2'd1);
        chk_all("R1 kernel write ro", 1, 3'b101, 8'h02);
        apply(mk(1,1,0,0), 5'b00000, 1'b1, 2'd1);
        chk_all("R1 user write ro", 1, 3'b101, 8'h02);
        apply(mk(1,1,0,0), 5'b00000, 1'b0, 2'd0);
        chk_all("R9 kernel read ro", 0, 3'b101, 8'h00);
    endtask

    task automatic t_kernel_fetch();
        apply(mk(0,1,1,0), 5'b00000, 1'b0, 2'd2);
        chk_all("R2 kernel fetch leaf kxn", 1, 3'b011, 8'h04);
        apply(mk(0,1,0,0), 5'b00001, 1'b0, 2'd2);
        chk_all("R2 kernel fetch rstr kxn", 1, 3'b011, 8'h04);
        apply(mk(0,1,0,1), 5'b00010, 1'b0, 2'd2);
        chk_all("R7 kernel fetch user xn only", 0, 3'b111, 8'h00);
        apply(mk(0,0,0,0), 5'b10100, 1'b0, 2'd0);
        chk_all("R2 kernel read user locks", 0, 3'b111, 8'h00);
    endtask

    task automatic t_user_data();
        apply(mk(0,1,0,0), 5'b00100, 1'b1, 2'd0);
        chk_all("R3 user read no_user_rw", 1, 3'b100, 8'h01);
        apply(mk(0,1,0,0), 5'b00100, 1'b1, 2'd2);
        chk_all("R10 user fetch no_user_rw", 0, 3'b100, 8'h00);
        apply(mk(0,1,0,0), 5'b00100, 1'b0, 2'd1);
        chk_all("R10 kernel write no_user_rw", 0, 3'b111, 8'h00);
    endtask

    task automatic t_user_fetch();
        apply(mk(0,1,0,1), 5'b00000, 1'b1, 2'd2);
        chk_all("R4 user fetch leaf uxn", 1, 3'b011, 8'h04);
        apply(mk(0,1,0,0), 5'b00010, 1'b1, 2'd2);
        chk_all("R4 user fetch rstr uxn", 1, 3'b011, 8'h04);
        apply(mk(0,1,1,0), 5'b00001, 1'b1, 2'd2);
        chk_all("R4 user fetch kernel xn only", 0, 3'b111, 8'h00);
    endtask

    task automatic t_user_lock();
        apply(mk(0,0,0,0), 5'b00000, 1'b1, 2'd0);
        chk_all("R5 user read kernel-only leaf", 1, 3'b000, 8'h01);
        apply(mk(0,1,0,0), 5'b10000, 1'b1, 2'd2);
        chk_all("R8 user fetch no_user", 1, 3'b000, 8'h04);
        apply(mk(0,0,0,0), 5'b10000, 1'b0, 2'd2);
        chk_all("R8 kernel fetch user locks", 0, 3'b111, 8'h00);
    endtask

    task automatic t_no_write();
        apply(mk(0,1,0,0), 5'b01000, 1'b0, 2'd1);
        chk_all("R9 kernel write no_write", 0, 3'b101, 8'h00);
        apply(mk(0,1,0,0), 5'b01000, 1'b1, 2'd1);
        chk_all("R9 user write no_write", 0, 3'b101, 8'h00);
    endtask

    task automatic t_debug();
        apply(mk(1,0,1,1), 5'b11111, 1'b1, 2'd3);
        chk_all("R6 debug user all locks", 0, 3'b000, 8'h00);
        apply(mk(1,1,1,0), 5'b01001, 1'b0, 2'd3);
        chk_all("R6 debug kernel", 0, 3'b001, 8'h00);
    endtask

    task automatic t_overlap();
        apply(mk(1,1,0,0), 5'b00100, 1'b1, 2'd1);
        chk_all("R11 user write ro and no_user_rw", 1, 3'b100, 8'h02);
        apply(mk(1,1,1,0), 5'b01000, 1'b0, 2'd2);
        chk_all("R11 kernel fetch xn with ro", 1, 3'b001, 8'h04);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_open();
        t_rdonly();
        t_kernel_fetch();
        t_user_data();
        t_user_fetch();
        t_user_lock();
        t_no_write();
        t_debug();
        t_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule